// File: doc/BRIEF.md
# Clock Source Selector with Missing-Clock Fallback

This block picks the system clock from three sources: an external crystal or PLL clock, a fast internal RC oscillator and a slow internal RC oscillator. Its control logic runs on the fast RC clock, which is always on. Out of reset the system runs from the fast RC while the request already points at the external source. The move to the external clock happens on its own once the oscillator reports that it is stable, which gives a two-speed start.

Each source passes through its own gating cell. A switch first shuts the old source off on one of its own falling edges and waits until that is confirmed. Only then does it open the new source, once the request has been synchronised into the new clock's domain. The output therefore never carries a shortened high or low phase.

While the external clock is in use, a detector counts slow-RC edges that pass with no external activity. When the limit is reached, the block falls back to the fast RC without software action. It also raises a sticky fail flag and an interrupt request. While the flag is set, a request for the external clock is refused.

Top module: `clksw_top`

## Requirements
- R1: After reset `cur_src` reads 0 (fast RC), `busy`, `fail_flag` and `fail_irq` are low, and `clk_sys` runs at the fast RC period.
- R2: The reset request selects the external source. While `ext_stable` is low the block stays on the fast RC. When `ext_stable` goes high it switches by itself to the external clock, and `cur_src` then reads 1.
- R3: A software write (`sel_wr`) with code 0 selects the fast RC, code 1 the external clock and code 2 the slow RC. After the switch `cur_src` equals the code and `clk_sys` has that source's period.
- R4: A write of code 3 has no effect. `cur_src` and the `clk_sys` period stay as they were and no switch starts.
- R5: No high or low phase of `clk_sys` is shorter than half the period of the faster of the two sources involved in a switch.
- R6: While the external source is in use or being brought up, if MISS_LIMIT (2) slow-RC rising edges pass with no external edge, the block moves to the fast RC without any write. `cur_src` ends at 0.
- R7: A running external clock never triggers the failure detection. `fail_flag` stays low.
- R8: On failover `fail_flag` and `fail_irq` go high. They stay high until a `fail_clr` write, which clears both.
- R9: While `fail_flag` is set, a write of code 1 is ignored. Once the flag is cleared and the external clock runs, the same write is accepted.
- R10: If a failover and a `fail_clr` write fall in the same cycle, the failover wins. The flag is raised and the fallback to the fast RC completes.
- R11: `busy` is high while a switch is in progress, and `cur_src` changes only at the end of a switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_frc | input | 1 | Fast internal RC clock; clocks the control logic |
| clk_ext | input | 1 | External crystal / PLL clock |
| clk_lrc | input | 1 | Slow internal RC clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_stable | input | 1 | External oscillator reports a stable clock |
| sel_wr | input | 1 | Write strobe for the requested source |
| sel_wdata | input | 2 | Requested source code (0 fast RC, 1 external, 2 slow RC, 3 reserved) |
| fail_clr | input | 1 | Write that clears the fail flag and the interrupt |
| clk_sys | output | 1 | Glitch-free selected system clock |
| cur_src | output | 2 | Source currently driving `clk_sys` |
| busy | output | 1 | A switch is in progress |
| fail_flag | output | 1 | Sticky external-clock failure flag |
| fail_irq | output | 1 | Interrupt request raised on failover |

## Verification
The two functions that can meet in one cycle are the missing-clock failover and the software clear of the fail flag. The bench provokes the collision by holding `fail_clr` high over the whole window in which it stops the external clock, so the detection cycle is certain to see a clear. The outcome counts as correct when a rising edge of `fail_flag` is observed and the system ends on the fast RC. Releasing the clear then leaves the flag low.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int NUM_SRC   = 3;
    localparam int CODE_W    = 2;
    localparam int SYNC_LEN  = 2;

    typedef enum logic [CODE_W-1:0] {
        SRC_FRC = 2'd0,
        SRC_EXT = 2'd1,
        SRC_LRC = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DROP  = 2'd1,
        ST_RAISE = 2'd2
    } sw_state_e;

    typedef struct packed {
        logic fail;
        logic irq;
    } fail_stat_t;

    function automatic logic code_is_source(input logic [CODE_W-1:0] code);
        return code != 2'd3;
    endfunction

    function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
        logic [NUM_SRC-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/clksw_gate.sv
module clksw_gate #(
    parameter bit RST_ON = 1'b0,
    parameter int SYNC_N = 2
) (
    input  logic clk_src,
    input  logic clk_ctl,
    input  logic rst,
    input  logic req,
    input  logic kill,
    output logic gclk,
    output logic ack
);
    logic [SYNC_N-1:0] req_sync;
    logic              en_q;
    logic [SYNC_N-1:0] ack_sync;

    // bring the request into the source domain
    always_ff @(posedge clk_src) begin
        if (rst) req_sync <= {SYNC_N{RST_ON}};
        else     req_sync <= {req_sync[SYNC_N-2:0], req};
    end

    // enable moves only while the source is low
    always_ff @(negedge clk_src) begin
        if (rst) en_q <= RST_ON;
        else     en_q <= req_sync[SYNC_N-1];
    end

    // report the enable back to the control domain
    always_ff @(posedge clk_ctl) begin
        if (rst) ack_sync <= {SYNC_N{RST_ON}};
        else     ack_sync <= {ack_sync[SYNC_N-2:0], en_q};
    end

    assign ack  = ack_sync[SYNC_N-1];
    assign gclk = clk_src & en_q & ~kill;

endmodule

// File: rtl/clksw_miss_det.sv
module clksw_miss_det #(
    parameter int MISS_LIMIT = 2,
    parameter int SYNC_N     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_ext,
    input  logic clk_lrc,
    input  logic arm,
    output logic miss
);
    localparam int CNT_W = $clog2(MISS_LIMIT + 1);

    logic             ext_tog;
    logic [SYNC_N:0]  tog_sync;
    logic [SYNC_N:0]  lrc_sync;
    logic [CNT_W-1:0] gap_cnt;
    logic             ext_seen;
    logic             lrc_tick;

    always_ff @(posedge clk_ext) begin
        if (rst) ext_tog <= 1'b0;
        else     ext_tog <= ~ext_tog;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_sync <= '0;
            lrc_sync <= '0;
        end else begin
            tog_sync <= {tog_sync[SYNC_N-1:0], ext_tog};
            lrc_sync <= {lrc_sync[SYNC_N-1:0], clk_lrc};
        end
    end

    assign ext_seen = tog_sync[SYNC_N] ^ tog_sync[SYNC_N-1];
    assign lrc_tick = lrc_sync[SYNC_N-1] & ~lrc_sync[SYNC_N];

    always_ff @(posedge clk) begin
        if (rst || !arm || ext_seen)           gap_cnt <= '0;
        else if (lrc_tick && gap_cnt < CNT_W'(MISS_LIMIT))
                                               gap_cnt <= gap_cnt + 1'b1;
    end

    assign miss = arm && !ext_seen && lrc_tick &&
                  (gap_cnt == CNT_W'(MISS_LIMIT - 1));

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_wr,
    input  logic [CODE_W-1:0]  sel_wdata,
    input  logic               fail_clr,
    input  logic               ext_stable,
    input  logic               miss,
    input  logic [NUM_SRC-1:0] gate_ack,
    output logic [NUM_SRC-1:0] gate_req,
    output logic               ext_kill,
    output src_e               cur_src,
    output logic               busy,
    output fail_stat_t         stat
);
    sw_state_e state_q;
    src_e      req_q, cur_q, nxt_q;
    logic      start_ok;
    logic      wr_ok;

    assign wr_ok = sel_wr && code_is_source(sel_wdata) &&
                   !(sel_wdata == SRC_EXT && stat.fail);

    always_comb begin
        start_ok = (req_q != cur_q);
        if (req_q == SRC_EXT && (!ext_stable || ext_kill)) start_ok = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= SRC_EXT;
            cur_q    <= SRC_FRC;
            nxt_q    <= SRC_FRC;
            gate_req <= src_onehot(SRC_FRC);
            ext_kill <= 1'b0;
            stat     <= '0;
        end else begin
            if (wr_ok) req_q <= src_e'(sel_wdata);
            if (fail_clr) stat <= '0;
            if (ext_kill && !gate_req[SRC_EXT] && !gate_ack[SRC_EXT])
                ext_kill <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        gate_req[cur_q] <= 1'b0;
                        nxt_q           <= req_q;
                        state_q         <= ST_DROP;
                    end
                end
                ST_DROP: begin
                    if (!gate_ack[cur_q]) begin
                        gate_req[nxt_q] <= 1'b1;
                        state_q         <= ST_RAISE;
                    end
                end
                ST_RAISE: begin
                    if (gate_ack[nxt_q]) begin
                        cur_q   <= nxt_q;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase

            // failover overrides any step taken above
            if (miss) begin
                gate_req[SRC_EXT] <= 1'b0;
                gate_req[SRC_FRC] <= 1'b1;
                ext_kill          <= 1'b1;
                stat              <= '{fail: 1'b1, irq: 1'b1};
                req_q             <= SRC_FRC;
                nxt_q             <= SRC_FRC;
                state_q           <= ST_RAISE;
            end
        end
    end

    assign cur_src = cur_q;
    assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter int MISS_LIMIT = 2
) (
    input  logic       clk_frc,
    input  logic       clk_ext,
    input  logic       clk_lrc,
    input  logic       rst,
    input  logic       ext_stable,
    input  logic       sel_wr,
    input  logic [1:0] sel_wdata,
    input  logic       fail_clr,
    output logic       clk_sys,
    output logic [1:0] cur_src,
    output logic       busy,
    output logic       fail_flag,
    output logic       fail_irq
);
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] gate_req;
    logic [NUM_SRC-1:0] gate_ack;
    logic [NUM_SRC-1:0] gate_kill;
    logic [NUM_SRC-1:0] gclk;
    logic               ext_kill;
    logic               miss;
    src_e               cur_e;
    fail_stat_t         stat;

    assign src_clk[SRC_FRC] = clk_frc;
    assign src_clk[SRC_EXT] = clk_ext;
    assign src_clk[SRC_LRC] = clk_lrc;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i == int'(SRC_EXT)) begin : g_kill
            assign gate_kill[i] = ext_kill;
        end else begin : g_nokill
            assign gate_kill[i] = 1'b0;
        end
        clksw_gate #(
            .RST_ON (i == int'(SRC_FRC)),
            .SYNC_N (SYNC_LEN)
        ) u_gate (
            .clk_src (src_clk[i]),
            .clk_ctl (clk_frc),
            .rst     (rst),
            .req     (gate_req[i]),
            .kill    (gate_kill[i]),
            .gclk    (gclk[i]),
            .ack     (gate_ack[i])
        );
    end

    clksw_miss_det #(
        .MISS_LIMIT (MISS_LIMIT),
        .SYNC_N     (SYNC_LEN)
    ) u_miss (
        .clk     (clk_frc),
        .rst     (rst),
        .clk_ext (clk_ext),
        .clk_lrc (clk_lrc),
        .arm     (gate_req[SRC_EXT]),
        .miss    (miss)
    );

    clksw_ctrl u_ctrl (
        .clk        (clk_frc),
        .rst        (rst),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .fail_clr   (fail_clr),
        .ext_stable (ext_stable),
        .miss       (miss),
        .gate_ack   (gate_ack),
        .gate_req   (gate_req),
        .ext_kill   (ext_kill),
        .cur_src    (cur_e),
        .busy       (busy),
        .stat       (stat)
    );

    assign clk_sys   = |gclk;
    assign cur_src   = cur_e;
    assign fail_flag = stat.fail;
    assign fail_irq  = stat.irq;

endmodule

// File: rtl/clksw_checker.sv
module clksw_checker (
    input logic       clk,
    input logic       rst,
    input logic       fail_clr,
    input logic [1:0] cur_src,
    input logic       busy,
    input logic       fail_flag,
    input logic       fail_irq,
    input logic [2:0] gate_req
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        fail_flag && !fail_clr |=> fail_flag);                        // R8

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_irq) |-> fail_flag);                               // R8

    AST_FAIL_FROM_EXT: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_flag) |-> ($past(cur_src) == 2'd1 || $past(busy))); // R6

    AST_SRC_MOVES_IN_SWITCH: assert property (@(posedge clk) disable iff (rst)
        cur_src != $past(cur_src) |-> $past(busy));                   // R11

    AST_NO_EXT_WHILE_FAILED: assert property (@(posedge clk) disable iff (rst)
        fail_flag && !busy |-> cur_src != 2'd1);                      // R9

    AST_NO_RESERVED_SRC: assert property (@(posedge clk) disable iff (rst)
        cur_src != 2'd3);                                             // R4

    AST_ONE_GATE_REQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_req));                                          // R5
endmodule

bind clksw_top clksw_checker u_chk (
    .clk       (clk_frc),
    .rst       (rst),
    .fail_clr  (fail_clr),
    .cur_src   (cur_src),
    .busy      (busy),
    .fail_flag (fail_flag),
    .fail_irq  (fail_irq),
    .gate_req  (gate_req)
);

// File: tb/tb_clksw_top.sv
`timescale 1ns/1ps
module tb_clksw_top;
    localparam real CLK_PERIOD = 10.0;
    localparam real EXT_PERIOD = 14.0;
    localparam real LRC_PERIOD = 200.0;
    localparam real MIN_PHASE  = 4.9;

    logic       clk_frc = 1'b0, clk_ext = 1'b0, clk_lrc = 1'b0;
    logic       rst = 1'b1, ext_stable = 1'b0, sel_wr = 1'b0, fail_clr = 1'b0;
    logic [1:0] sel_wdata = 2'd0;
    logic       clk_sys, busy, fail_flag, fail_irq;
    logic [1:0] cur_src;
    logic       ext_run = 1'b1;
    logic       mon_en = 1'b0;

    int n_checks = 0, n_fail = 0, glitch_cnt = 0, flag_rises = 0;
    realtime last_edge = 0;

    clksw_top dut (
        .clk_frc(clk_frc), .clk_ext(clk_ext), .clk_lrc(clk_lrc), .rst(rst),
        .ext_stable(ext_stable), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .fail_clr(fail_clr), .clk_sys(clk_sys), .cur_src(cur_src),
        .busy(busy), .fail_flag(fail_flag), .fail_irq(fail_irq)
    );

    always #(CLK_PERIOD/2) clk_frc = ~clk_frc;
    always #(LRC_PERIOD/2) clk_lrc = ~clk_lrc;
    always begin
        #(EXT_PERIOD/2);
        if (ext_run || clk_ext) clk_ext = ~clk_ext;
    end

    always @(clk_sys) begin
        if (mon_en && ($realtime - last_edge) < MIN_PHASE) glitch_cnt++;
        last_edge = $realtime;
    end

    always @(posedge fail_flag) flag_rises++;

    function automatic real exp_period(input logic [1:0] src);
        case (src)
            2'd1:    return EXT_PERIOD;
            2'd2:    return LRC_PERIOD;
            default: return CLK_PERIOD;
        endcase
    endfunction

    function automatic logic [1:0] exp_after_write(input logic [1:0] cur,
                                                   input logic [1:0] code,
                                                   input logic failed);
        if (code == 2'd3) return cur;
        if (code == 2'd1 && failed) return cur;
        return code;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_frc);
    endtask

    task automatic write_sel(input logic [1:0] code);
        @(negedge clk_frc);
        sel_wr = 1'b1; sel_wdata = code;
        @(negedge clk_frc);
        sel_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk_frc);
        fail_clr = 1'b1;
        @(negedge clk_frc);
        fail_clr = 1'b0;
    endtask

    task automatic wait_idle();
        cycles(3);
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk_frc);
        cycles(2);
    endtask

    task automatic check_period(input string req, input logic [1:0] src);
        realtime t0, p;
        @(posedge clk_sys); t0 = $realtime;
        @(posedge clk_sys); p = $realtime - t0;
        check((p > exp_period(src) - 0.5) && (p < exp_period(src) + 0.5),
              req, "clk_sys period ns", int'(p), int'(exp_period(src)));
        @(negedge clk_frc);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] model_src;
        int rises0;
        void'($urandom(32'd2024));
        cycles(100);
        rst = 1'b0;
        cycles(2);
        mon_en = 1'b1;

        // R1 reset state
        check(cur_src == 2'd0, "R1", "cur_src", cur_src, 0);
        check(!busy && !fail_flag && !fail_irq, "R1", "busy|flag|irq", {busy, fail_flag, fail_irq}, 0);
        check_period("R1", 2'd0);

        // R2 hold on fast RC until stable
        cycles(50);
        check(cur_src == 2'd0 && !busy, "R2", "cur_src before stable", cur_src, 0);
        ext_stable = 1'b1;
        wait_idle();
        check(cur_src == 2'd1, "R2", "cur_src after stable", cur_src, 1);
        check_period("R2", 2'd1);

        // R7 running external clock does not fail
        cycles(100);
        check(!fail_flag, "R7", "fail_flag", fail_flag, 0);

        // R11 busy during a switch, source unchanged until done
        write_sel(2'd2);
        @(negedge clk_frc);
        check(busy == 1'b1, "R11", "busy in switch", busy, 1);
        check(cur_src == 2'd1, "R11", "cur_src mid switch", cur_src, 1);
        wait_idle();
        model_src = 2'd2;
        check(cur_src == 2'd2, "R3", "cur_src slow RC", cur_src, 2);

        // R4 reserved code
        write_sel(2'd3);
        cycles(20);
        check(!busy && cur_src == 2'd2, "R4", "cur_src after code 3", cur_src, 2);
        check_period("R4", 2'd2);

        // R3 / R4 random selections
        for (int k = 0; k < 10; k++) begin
            logic [1:0] code;
            code = 2'($urandom_range(0, 3));
            write_sel(code);
            wait_idle();
            model_src = exp_after_write(model_src, code, 1'b0);
            check(cur_src == model_src, (code == 2'd3) ? "R4" : "R3",
                  "cur_src random", cur_src, model_src);
            check_period("R3", model_src);
        end

        // R6 / R8 failover
        write_sel(2'd1);
        wait_idle();
        check(cur_src == 2'd1, "R6", "on external before stop", cur_src, 1);
        ext_run = 1'b0;
        cycles(300);
        wait_idle();
        check(cur_src == 2'd0, "R6", "cur_src after failover", cur_src, 0);
        check(fail_flag && fail_irq, "R8", "flag&irq set", {fail_flag, fail_irq}, 3);
        check_period("R6", 2'd0);

        // R9 refusal while failed, R8 stickiness
        write_sel(2'd1);
        wait_idle();
        check(cur_src == exp_after_write(2'd0, 2'd1, 1'b1), "R9", "ext refused", cur_src, 0);
        cycles(50);
        check(fail_flag && fail_irq, "R8", "flag still set", {fail_flag, fail_irq}, 3);

        ext_run = 1'b1;
        cycles(50);
        pulse_clr();
        cycles(1);
        check(!fail_flag && !fail_irq, "R8", "flag&irq cleared", {fail_flag, fail_irq}, 0);
        write_sel(2'd1);
        wait_idle();
        check(cur_src == 2'd1, "R9", "ext accepted after clear", cur_src, 1);
        check_period("R9", 2'd1);

        // R10 failover coinciding with a clear write
        rises0 = flag_rises;
        @(negedge clk_frc);
        fail_clr = 1'b1;
        ext_run = 1'b0;
        cycles(300);
        wait_idle();
        fail_clr = 1'b0;
        cycles(2);
        check(flag_rises > rises0, "R10", "flag raised despite clear", flag_rises - rises0, 1);
        check(cur_src == 2'd0, "R10", "fallback completed", cur_src, 0);
        check(!fail_flag, "R10", "flag after clear held", fail_flag, 0);
        check_period("R10", 2'd0);

        // R5 glitch monitor result
        check(glitch_cnt == 0, "R5", "short clk_sys phases", glitch_cnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule